// File: doc/BRIEF.md
# Signed Restoring Sequential Divider

This block divides one WIDTH-bit two's-complement integer by another over several clock cycles. A one-cycle `start` pulse captures the dividend and divisor. The block then settles one quotient bit per cycle with a shift followed by a trial add or subtract. It keeps the partial remainder in an accumulator, the dividend and growing quotient in a second register, and the divisor in a third. After the last bit it fixes the sign of the quotient. It then presents quotient and remainder together with a one-cycle `done` pulse.

Each trial step picks subtraction when the accumulator and the divisor share a sign, and addition otherwise. A step counts as a success when the accumulator keeps its sign. It also counts as a success when the accumulator reaches exactly zero while every dividend bit still waiting in the quotient register is zero. On success the new quotient bit is 1. On failure the accumulator returns to its value before the trial. The final quotient is negated when the operand signs differ. A zero divisor skips the iteration and reports at once with a flag.

Top module: `sdiv_restoring`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle with `quotient`, `remainder`, `done` and `div_by_zero` all zero.
- R2: For a nonzero divisor, `done` is high in the cycle that follows the (WIDTH+1)-th rising edge after the edge that samples `start`. That is WIDTH+2 cycles after the cycle in which `start` is driven.
- R3: The quotient equals the dividend divided by the divisor, truncated toward zero. It is negative exactly when the operand signs differ and the magnitude is nonzero.
- R4: The remainder is zero or carries the dividend's sign. Its magnitude is below the divisor's magnitude, and quotient × divisor + remainder equals the dividend.
- R5: A zero divisor raises `done` in the cycle right after the sampling edge, with `div_by_zero` = 1, `quotient` = 0 and `remainder` = the dividend.
- R6: `div_by_zero` is 0 on every completion with a nonzero divisor.
- R7: `done` never stays high for two consecutive cycles, and it rises only as the result of an accepted `start`.
- R8: A `start` that arrives while a division is in progress is ignored. It neither changes that division's result nor produces an extra `done`.
- R9: Between completions, `quotient` and `remainder` hold their last values, even when the operand inputs change.
- R10: A negative dividend that is an exact multiple of the divisor yields a zero remainder. This covers divisors of magnitude one.
- R11: The most negative dividend gives correct results with any divisor other than -1. The most negative divisor also gives correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request that captures the operands while idle |
| dividend | input | WIDTH | Two's-complement dividend |
| divisor | input | WIDTH | Two's-complement divisor |
| quotient | output | WIDTH | Two's-complement quotient, truncated toward zero |
| remainder | output | WIDTH | Two's-complement remainder, sign of the dividend |
| done | output | 1 | One-cycle pulse marking new results |
| div_by_zero | output | 1 | Set with `done` when the divisor was zero |

## Verification
With a nonzero divisor, the results and `done` are due WIDTH+2 cycles after the cycle in which `start` is driven. With a zero divisor they are due one cycle later. The driver stamps every expected entry with its due cycle, taken from a free-running cycle count at the moment it raises `start`. The monitor samples on the falling edge and compares that stamp against the count when `done` appears. It flags an entry whose due cycle passes with no `done`, and it flags any `done` that arrives when no entry is waiting.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the signed restoring divider.
// Assumes: only the controller state encoding needs sharing.
package sdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } sdiv_state_e;

endpackage

// File: rtl/sdiv_iter_ctr.sv
`timescale 1ns/1ps
// Module: sdiv_iter_ctr
// Counts the trial steps already taken and flags the final one.
// Assumes: clear and advance are never both high; CW holds WIDTH.
module sdiv_iter_ctr #(
    parameter int WIDTH = 8,
    parameter int CW    = $clog2(WIDTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    output logic [CW-1:0] count,
    output logic          last
);

    localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

    logic [CW-1:0] count_q;

    // Step counter: zero on reset or clear, plus one per trial step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (advance) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
    assign last  = (count_q == LAST_IDX);

endmodule

// File: rtl/sdiv_step.sv
`timescale 1ns/1ps
// Module: sdiv_step
// One restoring step, purely combinational. It shifts the accumulator
// and quotient pair left, adds or subtracts the divisor according to
// the sign relation, and decides success from the accumulator's sign.
// A zero accumulator also counts as success when every unconsumed
// dividend bit is zero. Failure restores the shifted accumulator.
// Assumes: the accumulator is one bit wider than the operands, so the
// shifted partial remainder cannot overflow for any divisor.
module sdiv_step #(
    parameter int WIDTH = 8,
    parameter int CW    = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH:0]   acc_i,
    input  logic [WIDTH-1:0] quo_i,
    input  logic [WIDTH-1:0] dvs_i,
    input  logic [CW-1:0]    iter_i,
    output logic [WIDTH:0]   acc_o,
    output logic [WIDTH-1:0] quo_o
);

    localparam int AW = WIDTH + 1;

    logic [AW-1:0]    acc_sh;
    logic [WIDTH-1:0] quo_sh;
    logic [AW-1:0]    dvs_ext;
    logic [AW-1:0]    trial;
    logic [WIDTH-1:0] pend_mask;
    logic             pend_zero;
    logic             keep_sign;
    logic             step_ok;

    // Shift the pair left by one and sign-extend the divisor.
    always_comb begin
        acc_sh  = {acc_i[WIDTH-1:0], quo_i[WIDTH-1]};
        quo_sh  = {quo_i[WIDTH-2:0], 1'b0};
        dvs_ext = {dvs_i[WIDTH-1], dvs_i};
    end

    // Trial operation: subtract on equal signs, add otherwise.
    always_comb begin
        if (acc_sh[AW-1] == dvs_ext[AW-1]) begin
            trial = acc_sh - dvs_ext;
        end else begin
            trial = acc_sh + dvs_ext;
        end
    end

    // Dividend bits not yet shifted into the accumulator.
    always_comb begin
        pend_mask = {WIDTH{1'b1}} << (32'(iter_i) + 1);
        pend_zero = ((quo_sh & pend_mask) == '0);
    end

    // Decide success and pick the surviving accumulator and quotient bit.
    always_comb begin
        keep_sign = (trial[AW-1] == acc_sh[AW-1]);
        step_ok   = keep_sign || ((trial == '0) && pend_zero);
        acc_o     = step_ok ? trial : acc_sh;
        quo_o     = {quo_sh[WIDTH-1:1], step_ok};
    end

endmodule

// File: rtl/sdiv_sign_fix.sv
`timescale 1ns/1ps
// Module: sdiv_sign_fix
// Final correction: negates the raw quotient when the operand signs
// differ.
// Assumes: the raw quotient magnitude fits WIDTH bits as a signed value.
module sdiv_sign_fix #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] quo_raw,
    input  logic             negate,
    output logic [WIDTH-1:0] quo_out
);

    // Two's-complement negation on request.
    always_comb begin
        quo_out = negate ? (~quo_raw + 1'b1) : quo_raw;
    end

endmodule

// File: rtl/sdiv_restoring.sv
`timescale 1ns/1ps
// Module: sdiv_restoring
// Top of the signed restoring divider. A controller loads the
// operands, runs WIDTH restoring steps (one per cycle), then corrects
// the quotient sign and pulses done. A zero divisor completes right
// after the sampling edge with the flag set.
// Assumes: start is sampled only in idle; the most negative dividend
// divided by -1 is outside the supported range.
module sdiv_restoring #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             done,
    output logic             div_by_zero
);

    import sdiv_pkg::*;

    localparam int CW = $clog2(WIDTH + 1);
    localparam int AW = WIDTH + 1;

    sdiv_state_e      state_q;
    logic [AW-1:0]    acc_q;
    logic [WIDTH-1:0] quo_q;
    logic [WIDTH-1:0] dvs_q;
    logic             neg_q;
    logic             dvd_sign_q;
    logic [WIDTH-1:0] quotient_q;
    logic [WIDTH-1:0] remainder_q;
    logic             done_q;
    logic             dbz_q;

    logic [CW-1:0]    iter_cnt;
    logic             iter_last;
    logic [AW-1:0]    acc_nx;
    logic [WIDTH-1:0] quo_nx;
    logic [WIDTH-1:0] quo_fixed;
    logic             ctr_clear;
    logic             ctr_adv;

    assign ctr_clear = (state_q == ST_IDLE);
    assign ctr_adv   = (state_q == ST_RUN);

    sdiv_iter_ctr #(.WIDTH(WIDTH), .CW(CW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctr_clear),
        .advance (ctr_adv),
        .count   (iter_cnt),
        .last    (iter_last)
    );

    sdiv_step #(.WIDTH(WIDTH), .CW(CW)) u_step (
        .acc_i  (acc_q),
        .quo_i  (quo_q),
        .dvs_i  (dvs_q),
        .iter_i (iter_cnt),
        .acc_o  (acc_nx),
        .quo_o  (quo_nx)
    );

    sdiv_sign_fix #(.WIDTH(WIDTH)) u_fix (
        .quo_raw (quo_q),
        .negate  (neg_q),
        .quo_out (quo_fixed)
    );

    // Controller and datapath registers: load, iterate, correct, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            acc_q       <= '0;
            quo_q       <= '0;
            dvs_q       <= '0;
            neg_q       <= 1'b0;
            dvd_sign_q  <= 1'b0;
            quotient_q  <= '0;
            remainder_q <= '0;
            done_q      <= 1'b0;
            dbz_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (divisor == '0) begin
                            quotient_q  <= '0;
                            remainder_q <= dividend;
                            dbz_q       <= 1'b1;
                            done_q      <= 1'b1;
                        end else begin
                            acc_q      <= {AW{dividend[WIDTH-1]}};
                            quo_q      <= dividend;
                            dvs_q      <= divisor;
                            neg_q      <= dividend[WIDTH-1] ^ divisor[WIDTH-1];
                            dvd_sign_q <= dividend[WIDTH-1];
                            state_q    <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    acc_q <= acc_nx;
                    quo_q <= quo_nx;
                    if (iter_last) begin
                        state_q <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    quotient_q  <= quo_fixed;
                    remainder_q <= acc_q[WIDTH-1:0];
                    dbz_q       <= 1'b0;
                    done_q      <= 1'b1;
                    state_q     <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign quotient    = quotient_q;
    assign remainder   = remainder_q;
    assign done        = done_q;
    assign div_by_zero = dbz_q;

    // R7: done is a single-cycle pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R9: results hold between completions.
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> ($stable(quotient_q) && $stable(remainder_q)));

    // R5: a zero-divisor completion reports a zero quotient.
    assert_dbz_quot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && dbz_q) |-> (quotient_q == '0));

    // R3: a nonzero quotient is negative exactly when the signs differ.
    assert_quot_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !dbz_q && (quotient_q != '0)) |-> (quotient_q[WIDTH-1] == neg_q));

    // R4: a nonzero remainder carries the dividend's sign.
    assert_rem_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !dbz_q && (remainder_q != '0)) |-> (remainder_q[WIDTH-1] == dvd_sign_q));

    // R2: the step counter stays inside the WIDTH-step window.
    assert_iter_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (32'(iter_cnt) < WIDTH));

    // R8: a running division keeps its captured divisor whatever start does.
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> $stable(dvs_q));

endmodule

// File: tb/sdiv_restoring_test.sv
`timescale 1ns/1ps
// Scoreboard bench for sdiv_restoring: a driver queues expected
// results with their due cycle, a monitor compares on done.
module sdiv_restoring_test;

    localparam int W   = 8;
    localparam int LAT = W + 2;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic         z;
        int           a;
        int           b;
        int           due;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         done;
    logic         div_by_zero;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    int   stray_done = 0;
    exp_t sbq[$];

    sdiv_restoring #(.WIDTH(W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dividend    (dividend),
        .divisor     (divisor),
        .quotient    (quotient),
        .remainder   (remainder),
        .done        (done),
        .div_by_zero (div_by_zero)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Free-running cycle count for due-cycle stamps.
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: compare each done against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (sbq.size() == 0) begin
                    stray_done++;
                    chk(1'b0, "R7", "done without request", 1, 0);
                end else begin
                    exp_t e;
                    longint ident;
                    e = sbq.pop_front();
                    chk(cyc == e.due, e.req, "latency R2", cyc, e.due);
                    chk(quotient == e.q, e.req, "quotient R3",
                        $signed(quotient), $signed(e.q));
                    chk(remainder == e.r, e.req, "remainder R4",
                        $signed(remainder), $signed(e.r));
                    chk(div_by_zero == e.z, e.req, "flag R6", div_by_zero, e.z);
                    if (!e.z) begin
                        ident = longint'($signed(quotient)) * e.b + $signed(remainder);
                        chk(ident == e.a, e.req, "identity R4", ident, e.a);
                    end
                end
            end else if (sbq.size() > 0 && cyc > sbq[0].due) begin
                chk(1'b0, sbq[0].req, "missing done R2", cyc, sbq[0].due);
                void'(sbq.pop_front());
            end
        end
    end

    // Driver: issue one division and queue its expected outcome.
    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        exp_t e;
        logic signed [W-1:0] sa, sb;
        sa = a;
        sb = b;
        @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        e.a   = int'(sa);
        e.b   = int'(sb);
        e.req = req;
        if (b == '0) begin
            e.q = '0; e.r = a; e.z = 1'b1; e.due = cyc + 1;
        end else begin
            e.q = sa / sb; e.r = sa % sb; e.z = 1'b0; e.due = cyc + LAT;
        end
        sbq.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (sbq.size() > 0) @(negedge clk);
    endtask

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        issue(a, b, req);
        drain();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Main sequence.
    initial begin
        logic [W-1:0] hq, hr;
        repeat (3) @(negedge clk);
        chk(quotient == '0,  "R1", "reset quotient",  quotient, 0);
        chk(remainder == '0, "R1", "reset remainder", remainder, 0);
        chk(done == 1'b0,    "R1", "reset done",      done, 0);
        chk(div_by_zero == 1'b0, "R1", "reset flag",  div_by_zero, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: all four sign combinations.
        run(8'd7,   8'd3,   "R3");
        run(-8'sd7, 8'd3,   "R3");
        run(8'd7,   -8'sd3, "R3");
        run(-8'sd7, -8'sd3, "R3");
        run(8'd3,   8'd100, "R3");
        // R4: remainder sign and bound.
        run(8'd100, 8'd7,   "R4");
        run(-8'sd100, 8'd7, "R4");
        run(-8'sd100, -8'sd7, "R4");
        // R10: negative exact multiples.
        run(-8'sd6,   8'd3,   "R10");
        run(-8'sd5,   8'd1,   "R10");
        run(-8'sd5,   -8'sd1, "R10");
        run(-8'sd120, 8'd8,   "R10");
        run(-8'sd64,  -8'sd16, "R10");
        // R5: zero divisor.
        run(8'd5,    8'd0, "R5");
        run(8'h80,   8'd0, "R5");
        run(8'd0,    8'd0, "R5");
        // R6: a normal completion right after a zero-divisor one.
        run(8'd0,    8'd5, "R6");
        // R11: extreme operands.
        run(8'h80, 8'd3,   "R11");
        run(8'h80, 8'd1,   "R11");
        run(8'h80, 8'h80,  "R11");
        run(8'd127, 8'h80, "R11");
        run(8'h81, 8'h80,  "R11");
        run(8'd127, 8'd127, "R11");
        run(8'h80, 8'd127, "R11");

        // R8: start while busy is ignored.
        issue(8'd50, 8'd6, "R8");
        repeat (3) @(negedge clk);
        dividend = 8'd99;
        divisor  = 8'd0;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        drain();
        repeat (LAT + 3) @(negedge clk);
        chk(stray_done == 0, "R8", "extra done after busy start", stray_done, 0);
        chk(quotient == 8'd8, "R8", "quotient kept", quotient, 8);

        // R9: outputs hold while inputs move without start.
        run(-8'sd77, 8'd10, "R9");
        hq = quotient;
        hr = remainder;
        dividend = 8'd1;
        divisor  = 8'd1;
        repeat (6) @(negedge clk);
        chk(quotient == hq,  "R9", "quotient held",  quotient, hq);
        chk(remainder == hr, "R9", "remainder held", remainder, hr);
        chk(done == 1'b0,    "R9", "done idle",      done, 0);

        // R3/R4 sweep over random operands.
        for (int i = 0; i < 1500; i++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = (i % 4 == 0) ? W'($urandom % 5) : W'($urandom);
            if (ra == 8'h80 && rb == 8'hFF) rb = 8'h01;
            run(ra, rb, "R4");
        end

        // R7: no stray pulses over the whole run.
        repeat (LAT) @(negedge clk);
        chk(stray_done == 0, "R7", "stray done total", stray_done, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule